// File: doc/BRIEF.md
# PHY Control-Register Handshake Sequencer

This block turns a one-cycle command into the full series of request/acknowledge exchanges needed to reach a PHY's internal control registers. A local requester supplies an operation (latch an address, write a value, read a value) together with a 16-bit operand and pulses start. The sequencer then drives a control word made of the operand and one strobe bit at a time. For each strobe it waits for the PHY's acknowledge to rise. It then withdraws the strobe and waits for the acknowledge to fall.

The acknowledge passes through a two-flop synchronizer before it is compared. Acknowledge checks are spaced by a programmable gap of idle cycles. Each wait gives up after a fixed number of retries. A failed wait aborts the command, clears the control word and reports an error. A write takes two chained exchanges: data capture first, then the commit strobe. A read returns the low 16 bits of the PHY status while the acknowledge is high.

Top module: `phycr_hs_master`

## Requirements
- R1: The control word `ctl_o[19:0]` carries the operand in bits [15:0]. Bit 16 is capture-address, bit 17 is capture-data, bit 18 is the write commit and bit 19 is read. No more than one of bits [19:16] is set at a time.
- R2: Opcode 0 (address) drives the operand with bit 16 set and waits for acknowledge high. It then drives the operand with all strobes clear, waits for acknowledge low and completes.
- R3: Opcode 1 (write) runs four phases. First the operand with bit 17, waiting for high. Then the operand alone, waiting for low. Then the operand with bit 18, waiting for high. Finally an all-zero word, waiting for low. The PHY has then stored the operand at the last captured address.
- R4: Opcode 2 (read) drives only bit 19, with the operand field zero, and waits for acknowledge high. It latches `phy_rdata_i` into `rdata_o` at that point. It then drives zero and waits for low. `rdata_o` holds its value until the next successful read.
- R5: Each wait makes at most 101 acknowledge checks (MAX_RETRY = 100 retries after the first). The first check comes one cycle after the word is driven, and later checks come every `poll_gap_i`+1 cycles. When the last check misses, the command aborts with done and error, and the control word becomes all zero.
- R6: `start_i` is ignored while a command is in progress.
- R7: `done_o` is a one-cycle pulse per accepted command. `err_o` is high only in a cycle where `done_o` is high.
- R8: After a synchronous active-low reset, `ctl_o`, `done_o`, `err_o` and `rdata_o` are all zero.
- R9: Opcode 3 is reserved. Starting it gives done with error on the next clock edge, and no strobe bit is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Command start pulse |
| op_i | input | 2 | Opcode: 0 address, 1 write, 2 read, 3 reserved |
| val_i | input | 16 | Address or data operand |
| poll_gap_i | input | 8 | Idle cycles between acknowledge checks |
| phy_ack_i | input | 1 | PHY acknowledge, asynchronous |
| phy_rdata_i | input | 16 | Low half of PHY status word |
| ctl_o | output | 20 | Control word: operand plus strobes |
| done_o | output | 1 | Command completion pulse |
| err_o | output | 1 | Abort flag, valid with done |
| rdata_o | output | 16 | Last read result |

## Verification
The bench places a register-file model of the PHY behind the port. It checks writes through their read-back, so a design that chained the write strobes in the wrong order, or dropped a phase, returns stale data. It holds acknowledge stuck low and stuck high and counts the cycles to the abort. An off-by-one in the retry limit, or a gap that is not honoured, changes that count, and an abort that left a strobe raised is caught at done. It also re-pulses start in the middle of a write and starts the reserved opcode. A design that accepted the second start would produce an unexpected done, and one that ran the reserved opcode would drive a strobe.

// File: rtl/phycr_pkg.sv
// Shared types for the PHY control-register handshake sequencer.
// Assumes a four-strobe control word placed directly above the operand.
package phycr_pkg;
    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_RSVD  = 2'd3
    } phycr_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } phycr_state_e;

    // Strobe field encodings, one-hot, placed above the operand
    localparam logic [3:0] STB_NONE = 4'b0000;
    localparam logic [3:0] STB_CAPA = 4'b0001;
    localparam logic [3:0] STB_CAPD = 4'b0010;
    localparam logic [3:0] STB_WR   = 4'b0100;
    localparam logic [3:0] STB_RD   = 4'b1000;
endpackage

// File: rtl/phycr_bit_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes the input is a slow level (a handshake acknowledge), not a pulse.
module phycr_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/phycr_poll_pacer.sv
// Paces acknowledge checks. It flags a check when the gap counter is
// empty, reloads the gap after each check and counts the checks made.
// It assumes restart_i is pulsed whenever a new control word is driven.
module phycr_poll_pacer #(
    parameter int MAX_RETRY = 100,
    parameter int GAP_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             active_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             check_o,
    output logic             final_o
);
    localparam int TW = $clog2(MAX_RETRY + 1);

    logic [GAP_W-1:0] gap_cnt;
    logic [TW-1:0]    try_cnt;

    assign check_o = active_i && (gap_cnt == '0);
    assign final_o = (try_cnt == TW'(MAX_RETRY));

    // Count down the inter-check gap and the number of checks made
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            try_cnt <= '0;
        end else if (restart_i) begin
            gap_cnt <= '0;
            try_cnt <= '0;
        end else if (check_o) begin
            gap_cnt <= gap_i;
            if (!final_o) try_cnt <= try_cnt + TW'(1);
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - GAP_W'(1);
        end
    end
endmodule

// File: rtl/phycr_hs_master.sv
// Sequencer for PHY control-register transactions over a four-phase
// request/acknowledge handshake. Each command is a short list of
// (control word, expected acknowledge) steps, which are walked in order.
// It assumes phy_rdata_i is stable while the acknowledge is high.
module phycr_hs_master
    import phycr_pkg::*;
#(
    parameter int DW        = 16,
    parameter int MAX_RETRY = 100,
    parameter int GAP_W     = 8,
    parameter int SYNC_ST   = 2,
    localparam int CW       = DW + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [DW-1:0]    val_i,
    input  logic [GAP_W-1:0] poll_gap_i,
    input  logic             phy_ack_i,
    input  logic [DW-1:0]    phy_rdata_i,
    output logic [CW-1:0]    ctl_o,
    output logic             done_o,
    output logic             err_o,
    output logic [DW-1:0]    rdata_o
);
    phycr_state_e  state;
    phycr_op_e     cur_op;
    logic [DW-1:0] cur_val;
    logic [1:0]    step;
    logic          ack_s;
    logic          check, final_try, restart, busy;
    logic          match, last_step;
    phycr_op_e     req_op;

    assign req_op = phycr_op_e'(op_i);
    assign busy   = (state == ST_WAIT);

    // Control word for a given command and step
    function automatic logic [CW-1:0] step_word(phycr_op_e op, logic [DW-1:0] v,
                                                logic [1:0] s);
        logic [CW-1:0] w;
        w = '0;
        case (op)
            OP_ADDR:  w = (s == 2'd0) ? {STB_CAPA, v} : {STB_NONE, v};
            OP_WRITE: case (s)
                          2'd0:    w = {STB_CAPD, v};
                          2'd1:    w = {STB_NONE, v};
                          2'd2:    w = {STB_WR, v};
                          default: w = '0;
                      endcase
            OP_READ:  w = (s == 2'd0) ? {STB_RD, {DW{1'b0}}} : '0;
            default:  w = '0;
        endcase
        return w;
    endfunction

    phycr_bit_sync #(.STAGES(SYNC_ST)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d_i(phy_ack_i), .q_o(ack_s)
    );

    phycr_poll_pacer #(.MAX_RETRY(MAX_RETRY), .GAP_W(GAP_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .active_i(busy),
        .gap_i(poll_gap_i), .check_o(check), .final_o(final_try)
    );

    // Even steps wait for acknowledge high, odd steps for low
    assign match = (ack_s == ~step[0]);

    // Decide whether the current step is the final one of its command
    always_comb begin
        case (cur_op)
            OP_WRITE: last_step = (step == 2'd3);
            default:  last_step = (step == 2'd1);
        endcase
    end

    // Restart the pacer whenever a fresh control word is driven
    assign restart = (!busy && start_i && req_op != OP_RSVD) ||
                     (busy && check && match && !last_step);

    // Command state machine: accept, advance through steps, finish or abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_op  <= OP_ADDR;
            cur_val <= '0;
            step    <= '0;
            ctl_o   <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (state)
                ST_IDLE: if (start_i) begin
                    if (req_op == OP_RSVD) begin
                        done_o <= 1'b1;
                        err_o  <= 1'b1;
                    end else begin
                        cur_op  <= req_op;
                        cur_val <= val_i;
                        step    <= 2'd0;
                        ctl_o   <= step_word(req_op, val_i, 2'd0);
                        state   <= ST_WAIT;
                    end
                end
                ST_WAIT: if (check) begin
                    if (match) begin
                        if (cur_op == OP_READ && step == 2'd0) rdata_o <= phy_rdata_i;
                        if (last_step) begin
                            done_o <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            step  <= step + 2'd1;
                            ctl_o <= step_word(cur_op, cur_val, step + 2'd1);
                        end
                    end else if (final_try) begin
                        ctl_o  <= '0;
                        done_o <= 1'b1;
                        err_o  <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phycr_hs_checker.sv
// Protocol checker for phycr_hs_master, attached by bind. It observes
// the control word, the completion flags and the busy state.
module phycr_hs_checker #(
    parameter int CW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic [CW-1:0] ctl_o,
    input logic          done_o,
    input logic          err_o
);
    // R1: never more than one strobe raised
    p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_o[CW-1:CW-4]));

    // R2: strobes only appear while a command is in progress
    p_strobe_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ctl_o[CW-1:CW-4] == 4'b0000));

    // R4: the read strobe carries a zero operand field
    p_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o[CW-1] |-> (ctl_o[CW-5:0] == '0));

    // R5: an abort out of a wait leaves the control word all zero
    p_abort_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o && $past(busy)) |-> (ctl_o == '0));

    // R6: a command in progress is not replaced; busy falls only with done
    p_busy_ends_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_o);

    // R7: done lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: error only together with done
    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);
endmodule

bind phycr_hs_master phycr_hs_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ctl_o(ctl_o),
    .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_phycr_hs_master.sv
`timescale 1ns/1ps
module tb_phycr_hs_master;
    localparam int MAXR = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [15:0] val = '0;
    logic [7:0]  gap = 8'd0;
    logic        ack;
    logic [15:0] prdata;
    logic [19:0] ctl;
    logic        done, err;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    phycr_hs_master dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .val_i(val),
        .poll_gap_i(gap), .phy_ack_i(ack), .phy_rdata_i(prdata),
        .ctl_o(ctl), .done_o(done), .err_o(err), .rdata_o(rdata)
    );

    // PHY model: register file, acknowledge after a 3-cycle delay
    int          mode = 0;   // 0 normal, 1 stuck low, 2 stuck high
    logic [15:0] mem [16];
    logic [15:0] pa, pd;
    logic [3:0]  prev_stb;
    logic [2:0]  ack_pipe;

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'h0;
        pa = '0; pd = '0; prev_stb = '0; ack_pipe = '0;
    end

    always @(posedge clk) begin
        ack_pipe <= {ack_pipe[1:0], |ctl[19:16]};
        prev_stb <= ctl[19:16];
        if (ctl[16] && !prev_stb[0]) pa <= ctl[15:0];
        if (ctl[17] && !prev_stb[1]) pd <= ctl[15:0];
        if (ctl[18] && !prev_stb[2]) mem[pa[3:0]] <= pd;
    end

    assign ack    = (mode == 1) ? 1'b0 : (mode == 2) ? 1'b1 : ack_pipe[2];
    assign prdata = ctl[19] ? mem[pa[3:0]] : 16'h0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Scoreboard of expected completions
    typedef struct {
        bit          e_err;
        bit          chk_rd;
        logic [15:0] e_rd;
        string       tag;
    } exp_t;
    exp_t sb[$];
    bit   prev_done = 0;

    // Monitor: pop and compare at every done pulse (R7 pulse width too)
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) check(0, "R7 done wider than one cycle", 1, 0);
            if (!done && err) check(0, "R7 error without done", 1, 0);
            if (done) begin
                if (sb.size() == 0) begin
                    check(0, "R6 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(err == e.e_err, {e.tag, " error flag"}, err, e.e_err);
                    if (e.chk_rd) check(rdata == e.e_rd, {e.tag, " read data"}, rdata, e.e_rd);
                end
            end
        end
        prev_done <= done;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual %0d expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic pulse_start(input logic [1:0] o, input logic [15:0] v);
        @(negedge clk);
        op = o; val = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_op(input logic [1:0] o, input logic [15:0] v, input bit e_err,
                          input bit chk_rd, input logic [15:0] e_rd, input string tag);
        exp_t e;
        e.e_err = e_err; e.chk_rd = chk_rd; e.e_rd = e_rd; e.tag = tag;
        sb.push_back(e);
        pulse_start(o, v);
        drain();
    endtask

    // Stuck acknowledge: check first word layout and cycles to abort
    task automatic timed_abort(input logic [1:0] o, input logic [15:0] v,
                               input logic [19:0] first_word, input int exp_n,
                               input string tag);
        exp_t e;
        int   n;
        e.e_err = 1; e.chk_rd = 0; e.e_rd = '0; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        op = o; val = v; start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        check(ctl == first_word, {tag, " R1 first control word"}, ctl, first_word);
        n = 0;
        while (!done && n < 2000) begin
            @(posedge clk);
            #1;
            n++;
        end
        check(n == exp_n, {tag, " R5 cycles to abort"}, n, exp_n);
        check(ctl == 20'h0, {tag, " R5 word cleared on abort"}, ctl, 0);
        drain();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R8: reset state
        check(ctl == 20'h0, "R8 ctl after reset", ctl, 0);
        check(done == 1'b0, "R8 done after reset", done, 0);
        check(err == 1'b0, "R8 err after reset", err, 0);
        check(rdata == 16'h0, "R8 rdata after reset", rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1, R5: stuck-low acknowledge, gap 2 -> 1 + 100*3 cycles
        mode = 1; gap = 8'd2;
        timed_abort(2'd0, 16'h0ABC, 20'h10ABC, 1 + MAXR * 3, "addr stuck low");
        timed_abort(2'd1, 16'h1234, 20'h21234, 1 + MAXR * 3, "write stuck low");
        gap = 8'd0;
        timed_abort(2'd2, 16'hFFFF, 20'h80000, 1 + MAXR, "read stuck low");
        // R5: stuck high -> first wait passes at once, second one aborts
        mode = 2; gap = 8'd1;
        timed_abort(2'd0, 16'h0005, 20'h10005, 2 + MAXR * 2, "addr stuck high");

        // R2, R3, R4: normal traffic at several gaps
        mode = 0;
        gap = 8'd0;
        run_op(2'd0, 16'h0003, 0, 0, 0, "R2 addr 3");
        run_op(2'd1, 16'hA5A5, 0, 0, 0, "R3 write A5A5");
        run_op(2'd0, 16'h0007, 0, 0, 0, "R2 addr 7");
        run_op(2'd1, 16'h0F0F, 0, 0, 0, "R3 write 0F0F");
        gap = 8'd5;
        run_op(2'd0, 16'h0003, 0, 0, 0, "R2 addr 3 gap5");
        run_op(2'd2, 16'h0000, 0, 1, 16'hA5A5, "R4 read addr 3");
        gap = 8'd3;
        run_op(2'd0, 16'h0007, 0, 0, 0, "R2 addr 7 gap3");
        run_op(2'd2, 16'h0000, 0, 1, 16'h0F0F, "R4 read addr 7");
        run_op(2'd0, 16'h000C, 0, 0, 0, "R2 addr C");
        run_op(2'd2, 16'hBEEF, 0, 1, 16'h0000, "R4 read unwritten addr C");

        // R6: second start during a write must be ignored
        gap = 8'd1;
        begin
            exp_t e;
            e.e_err = 0; e.chk_rd = 0; e.e_rd = '0; e.tag = "R6 write under restart";
            run_op(2'd0, 16'h0009, 0, 0, 0, "R2 addr 9");
            sb.push_back(e);
            pulse_start(2'd1, 16'h5AA5);
            repeat (6) @(negedge clk);
            pulse_start(2'd2, 16'h0000);
            repeat (6) @(negedge clk);
            pulse_start(2'd0, 16'h0001);
            drain();
        end
        run_op(2'd2, 16'h0000, 0, 1, 16'h5AA5, "R6 read back addr 9 intact");

        // R9: reserved opcode, completes with error, no strobe, rdata kept
        @(negedge clk);
        sb.push_back('{e_err: 1, chk_rd: 1, e_rd: 16'h5AA5, tag: "R9 reserved op"});
        op = 2'd3; val = 16'h1111; start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        check(done == 1'b1, "R9 done after one edge", done, 1);
        check(ctl[19:16] == 4'h0, "R9 no strobe raised", ctl[19:16], 0);
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule